// File: doc/BRIEF.md
# Multi-Mode Timer Channel Counter

This block is one channel of an event and time counter. It has four ways of counting. In edge mode it counts chosen transitions of one input pin. In gated mode it counts enabled cycles of the internal clock while that pin is high, so the final count is the pin's high time. In quadrature mode it decodes two phase inputs into up and down steps. In direction mode it counts one step per strobe edge, up or down according to a second pin.

The count runs from zero to a programmable terminal value. Stepping up past that value returns the count to zero. Stepping down from zero sets the count to the terminal value. Every wrap raises a flag for one cycle. A synchronous clear and a synchronous load let the surrounding logic start a measurement from a known value.

Both pins pass through a two-flop synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier.

Top module: `mmt_chan`

## Requirements
- R1: While rst_n is low, count is 0 and tc_flag is 0.
- R2: With mode 00 (edge), each transition of pin_a picked by edge_sel adds one: 01 picks rising edges, 10 falling edges, 11 both, and 00 none.
- R3: With mode 01 (gated), count adds one on each cycle in which the synchronized pin_a is high and clk_en is high. When either is low, count holds.
- R4: With mode 10 (quadrature), the pair {pin_a,pin_b} stepping 00→10→11→01→00 counts up by one per change, and the reverse order counts down. A change of both pins at once is ignored.
- R5: With mode 11 (direction), each rising edge of pin_a steps the count up by one when pin_b is high and down by one when pin_b is low. Falling edges of pin_a do nothing.
- R6: An up step when count is greater than or equal to modulo sets count to 0.
- R7: A down step when count is 0 sets count to modulo.
- R8: tc_flag is high for exactly one cycle, in the same cycle as the count update of each wrap from R6 or R7, and at no other time.
- R9: clr sets count to 0 on the next clock and takes priority over load and counting. It never raises tc_flag.
- R10: load (without clr) sets count to load_val on the next clock and takes priority over any step.
- R11: A change on a pin that produces a step shows on count after the third rising clock edge, and not after the second.
- R12: clk_en affects only gated mode. In the other modes, steps happen whatever its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 edge, 01 gated, 10 quadrature, 11 direction |
| edge_sel | input | 2 | Edge choice in edge mode: 01 rise, 10 fall, 11 both, 00 none |
| clk_en | input | 1 | Prescaled time-base enable for gated mode |
| pin_a | input | 1 | Event input, gate, phase A or strobe |
| pin_b | input | 1 | Phase B or direction |
| clr | input | 1 | Synchronous clear of the count |
| load | input | 1 | Synchronous load of load_val |
| load_val | input | W | Value for load |
| modulo | input | W | Terminal count value |
| count | output | W | Current count |
| tc_flag | output | 1 | One-cycle wrap pulse |

## Verification
The bench builds the channel with W = 6 and picks random terminal values between 0 and 9, so a few steps are enough to wrap in both directions. A terminal value of 0 is also reached, so a single step can wrap from 0 to 0 in either direction. The narrow width also keeps every loaded start value close to a wrap point. Random quadrature moves include diagonal jumps, so ignored illegal transitions appear among legal steps in both directions.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  typedef enum logic [1:0] {
    MODE_EDGE  = 2'b00,
    MODE_GATED = 2'b01,
    MODE_QUAD  = 2'b10,
    MODE_DIR   = 2'b11
  } mmt_mode_e;

  // Position of a two-phase state along the up-counting cycle 00,10,11,01
  function automatic logic [1:0] quad_pos(input logic a, input logic b);
    case ({a, b})
      2'b00:   quad_pos = 2'd0;
      2'b10:   quad_pos = 2'd1;
      2'b11:   quad_pos = 2'd2;
      default: quad_pos = 2'd3;
    endcase
  endfunction

  // True when the level change of a signal is one of the selected edges
  function automatic logic edge_hit(input logic [1:0] sel, input logic now_v,
                                    input logic old_v);
    edge_hit = (sel[0] & now_v & ~old_v) | (sel[1] & ~now_v & old_v);
  endfunction
endpackage

// File: rtl/mmt_sync.sv
module mmt_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= raw[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[i] = s2;
    assign prv[i] = s3;
  end
endmodule

// File: rtl/mmt_decode.sv
module mmt_decode
  import mmt_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] edge_sel,
  input  logic       clk_en,
  input  logic [1:0] lvl,   // [0] pin_a, [1] pin_b
  input  logic [1:0] prv,
  output logic       step_up,
  output logic       step_dn
);
  logic [1:0] pos_now, pos_old, pos_diff;

  always_comb begin
    pos_now  = quad_pos(lvl[0], lvl[1]);
    pos_old  = quad_pos(prv[0], prv[1]);
    pos_diff = pos_now - pos_old;
    step_up  = 1'b0;
    step_dn  = 1'b0;
    case (mmt_mode_e'(mode))
      MODE_EDGE:  step_up = edge_hit(edge_sel, lvl[0], prv[0]);
      MODE_GATED: step_up = lvl[0] & clk_en;
      MODE_QUAD: begin
        step_up = (pos_diff == 2'd1);
        step_dn = (pos_diff == 2'd3);
      end
      default: begin
        step_up = edge_hit(2'b01, lvl[0], prv[0]) & lvl[1];
        step_dn = edge_hit(2'b01, lvl[0], prv[0]) & ~lvl[1];
      end
    endcase
  end
endmodule

// File: rtl/mmt_count.sv
module mmt_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] modulo,
  input  logic         step_up,
  input  logic         step_dn,
  output logic [W-1:0] count,
  output logic         tc_flag
);
  logic [W-1:0] nxt;
  logic         wrap;

  always_comb begin
    nxt  = count;
    wrap = 1'b0;
    if (step_up) begin
      if (count >= modulo) begin
        nxt  = '0;
        wrap = 1'b1;
      end else begin
        nxt = count + 1'b1;
      end
    end else if (step_dn) begin
      if (count == '0) begin
        nxt  = modulo;
        wrap = 1'b1;
      end else begin
        nxt = count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      tc_flag <= 1'b0;
    end else if (clr) begin
      count   <= '0;
      tc_flag <= 1'b0;
    end else if (load) begin
      count   <= load_val;
      tc_flag <= 1'b0;
    end else begin
      count   <= nxt;
      tc_flag <= wrap;
    end
  end
endmodule

// File: rtl/mmt_chan.sv
module mmt_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [1:0]   edge_sel,
  input  logic         clk_en,
  input  logic         pin_a,
  input  logic         pin_b,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] modulo,
  output logic [W-1:0] count,
  output logic         tc_flag
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_lvl, pin_prv;
  logic            step_up, step_dn;
  logic            a_chg, b_chg, gate_lvl;

  assign a_chg    = pin_lvl[0] ^ pin_prv[0];
  assign b_chg    = pin_lvl[1] ^ pin_prv[1];
  assign gate_lvl = pin_lvl[0];

  mmt_sync #(.N(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({pin_b, pin_a}),
    .lvl(pin_lvl), .prv(pin_prv)
  );

  mmt_decode u_dec (
    .mode(mode), .edge_sel(edge_sel), .clk_en(clk_en),
    .lvl(pin_lvl), .prv(pin_prv), .step_up(step_up), .step_dn(step_dn)
  );

  mmt_count #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_val(load_val),
    .modulo(modulo), .step_up(step_up), .step_dn(step_dn),
    .count(count), .tc_flag(tc_flag)
  );
endmodule

// File: rtl/mmt_chan_chk.sv
module mmt_chan_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         clk_en,
  input logic         clr,
  input logic         load,
  input logic [W-1:0] load_val,
  input logic [W-1:0] modulo,
  input logic [W-1:0] count,
  input logic         tc_flag,
  input logic         step_up,
  input logic         step_dn,
  input logic         a_chg,
  input logic         b_chg,
  input logic         gate_lvl
);
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |-> (count == '0 && !tc_flag));

  a_r3_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !(gate_lvl && clk_en) && !clr && !load) |=> count == $past(count));

  a_r4_quad_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && a_chg && b_chg) |-> (!step_up && !step_dn));

  a_r6_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !clr && !load && count >= modulo) |=> (count == '0 && tc_flag));

  a_r7_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !clr && !load && count == '0) |=> (count == $past(modulo) && tc_flag));

  a_r8_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tc_flag |-> $past((step_up || step_dn) && !clr && !load));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !tc_flag));

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (count == $past(load_val) && !tc_flag));

  a_r4_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));
endmodule

bind mmt_chan mmt_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .clk_en(clk_en), .clr(clr),
  .load(load), .load_val(load_val), .modulo(modulo), .count(count),
  .tc_flag(tc_flag), .step_up(step_up), .step_dn(step_dn),
  .a_chg(a_chg), .b_chg(b_chg), .gate_lvl(gate_lvl)
);

// File: tb/sim_mmt_chan.sv
module sim_mmt_chan;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [1:0]   edge_sel = 2'b00;
  logic         clk_en = 1'b0;
  logic         pin_a = 1'b0;
  logic         pin_b = 1'b0;
  logic         clr = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] modulo = '0;
  logic [W-1:0] count;
  logic         tc_flag;

  int n_chk = 0, n_bad = 0, tc_seen = 0, tc_exp = 0;
  int m_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mmt_chan #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .edge_sel(edge_sel), .clk_en(clk_en),
    .pin_a(pin_a), .pin_b(pin_b), .clr(clr), .load(load), .load_val(load_val),
    .modulo(modulo), .count(count), .tc_flag(tc_flag)
  );

  always @(negedge clk) if (rst_n && tc_flag) tc_seen++;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int qpos(bit a, bit b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  // Expected step (+1, -1, 0) of a pin change in a non-gated mode
  function automatic int exp_step(int md, int es, bit oa, bit ob, bit na, bit nb);
    int d;
    case (md)
      0: return ((es & 1) && !oa && na) || ((es & 2) && oa && !na) ? 1 : 0;
      2: begin
        d = (qpos(na, nb) - qpos(oa, ob) + 4) % 4;
        return d == 1 ? 1 : (d == 3 ? -1 : 0);
      end
      3: return (!oa && na) ? (nb ? 1 : -1) : 0;
      default: return 0;
    endcase
  endfunction

  function automatic void apply(int s);
    if (s > 0) begin
      if (m_cnt >= int'(modulo)) begin m_cnt = 0; tc_exp++; end
      else m_cnt++;
    end else if (s < 0) begin
      if (m_cnt == 0) begin m_cnt = int'(modulo); tc_exp++; end
      else m_cnt--;
    end
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(bit na, bit nb, string tag);
    apply(exp_step(int'(mode), int'(edge_sel), pin_a, pin_b, na, nb));
    pin_a = na;
    pin_b = nb;
    tick(4);
    check(tag, int'(count), m_cnt);
    check("R8 tc pulses", tc_seen, tc_exp);
  endtask

  task automatic gate_pulse(int n, string tag);
    clk_en = 1'b1;
    pin_a = 1'b1;
    tick(n);
    pin_a = 1'b0;
    for (int i = 0; i < n; i++) apply(1);
    tick(4);
    check(tag, int'(count), m_cnt);
    check("R8 tc pulses", tc_seen, tc_exp);
  endtask

  task automatic do_load(int v);
    load_val = W'(v);
    load = 1'b1;
    tick(1);
    load = 1'b0;
    m_cnt = v;
    check("R10 load", int'(count), v);
  endtask

  task automatic enter_mode(int md);
    set_pins(1'b0, 1'b0, "R2 return pins low");
    mode = md[1:0];
    tick(1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    tick(2);
    check("R1 reset count", int'(count), 0);
    check("R1 reset tc", int'(tc_flag), 0);
    rst_n = 1'b1;
    tick(1);

    // R11 latency: rising edge of pin_a in edge mode
    modulo = 6'd9;
    edge_sel = 2'b01;
    pin_a = 1'b1;
    tick(2);
    check("R11 no change after 2 edges", int'(count), 0);
    tick(1);
    check("R11 change after 3 edges", int'(count), 1);
    m_cnt = 1;
    set_pins(1'b0, 1'b0, "R2 fall ignored with sel 01");
    edge_sel = 2'b00;
    set_pins(1'b1, 1'b0, "R2 sel 00 no count");
    set_pins(1'b0, 1'b0, "R2 sel 00 no count");

    // R9 clear wins over load
    clr = 1'b1; load = 1'b1; load_val = 6'd5;
    tick(1);
    clr = 1'b0; load = 1'b0;
    m_cnt = 0;
    check("R9 clear priority", int'(count), 0);

    // R7 down wrap, R6 up wrap, R5 direction
    mode = 2'b11;
    modulo = 6'd4;
    set_pins(1'b1, 1'b0, "R7 down wrap to modulo");
    check("R7 value", int'(count), 4);
    set_pins(1'b0, 1'b1, "R5 falling strobe ignored");
    set_pins(1'b1, 1'b1, "R6 up wrap to zero");
    check("R6 value", int'(count), 0);

    // R10 load overrides a step in the same cycle
    set_pins(1'b0, 1'b1, "R5 strobe low");
    pin_a = 1'b1;
    tick(2);
    load_val = 6'd2; load = 1'b1;
    tick(1);
    load = 1'b0;
    tick(2);
    m_cnt = 2;
    check("R10 load beats step", int'(count), 2);
    pin_a = 1'b0;
    tick(4);

    // R3 gated with clk_en low holds, R4 diagonal ignored
    enter_mode(1);
    clk_en = 1'b0;
    pin_a = 1'b1;
    tick(6);
    pin_a = 1'b0;
    tick(4);
    check("R3 clk_en low holds", int'(count), m_cnt);
    enter_mode(2);
    set_pins(1'b1, 1'b1, "R4 diagonal ignored");

    // Constrained random segments
    for (int seg = 0; seg < 40; seg++) begin
      int md;
      md = $urandom_range(0, 3);
      enter_mode(md);
      modulo = W'($urandom_range(0, 9));
      do_load($urandom_range(0, int'(modulo)));
      edge_sel = 2'($urandom_range(0, 3));
      for (int k = 0; k < 12; k++) begin
        if (md == 1) begin
          gate_pulse($urandom_range(1, 7), "R3 gated count");
        end else begin
          clk_en = 1'($urandom_range(0, 1));
          set_pins(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   md == 0 ? "R2 edge count" : (md == 2 ? "R4 quad count" : "R5 dir count R12"));
        end
      end
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule